// File: doc/BRIEF.md
# Grouped-priority interrupt arbiter

This block collects up to 240 interrupt request lines and chooses which one a processor core should service next. Every line owns an enable bit, a pending bit and a priority byte that software may rewrite at any moment. Of that byte only a parameterised number of upper bits are stored. The lower bits are dropped on write and show up as zero wherever the priority is visible. Among all lines that are both pending and enabled, the arbiter picks the one with the smallest priority value. When two values are equal, the smaller line number wins.

A three-bit grouping selector splits each priority byte into a preemption group above the split point and a subpriority below it. The winner is flagged for preemption only when the core is idle, or when the winner's group field is strictly smaller than the group field of the level the core is running at. Subpriority orders pending requests but never causes preemption. The core returns an acknowledge with the line number it accepted, and that acknowledge clears the pending bit. Stacking, vector fetch and bus decoding sit outside this block.

Top module: `irq_group_arbiter`

## Requirements
- R1: After a synchronous active-low reset, all outputs are zero and every pending bit, enable bit and stored priority is zero.
- R2: A low-to-high transition on a request line sets its pending bit. A line held high does not set the bit again once it has been cleared.
- R3: A software pending write with value 1 sets the pending bit of the indexed line, and value 0 clears it. When a set and a clear hit the same line in the same cycle, the set wins.
- R4: An acknowledge clears the pending bit of the acknowledged line number.
- R5: Only lines that are both pending and enabled compete. A pending line that is disabled keeps its pending bit and competes once it is enabled.
- R6: The winner is the competing line with the smallest stored priority value. Equal values go to the smaller line number.
- R7: A priority write keeps only the upper PRIO_BITS bits of the written byte. The reported winner priority is a byte whose lower 8-PRIO_BITS bits are zero.
- R8: A priority write that lands at clock edge E changes the arbitration result that the outputs show after edge E+1.
- R9: A grouping selector value g makes priority bits [7:g+1] the preemption group and bits [g:0] the subpriority. With g=7 there are no group bits.
- R10: While the core is idle (current-active input low), any valid winner raises the preempt output.
- R11: While the core is active, preempt is raised only if the winner's group field is strictly smaller than the group field of the current-priority input. A winner whose group field is equal to that value does not preempt, whatever the subpriority bits are.
- R12: When no line is both pending and enabled, the valid output and the preempt output are low, and the winner number and winner priority outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | NUM_IRQ | Request lines; a rising level marks the line pending |
| en_wr_i | input | 1 | Enable write strobe |
| en_idx_i | input | ID_W | Line addressed by the enable write |
| en_val_i | input | 1 | New enable value |
| pend_wr_i | input | 1 | Software pending write strobe |
| pend_idx_i | input | ID_W | Line addressed by the pending write |
| pend_val_i | input | 1 | 1 sets pending, 0 clears it |
| prio_wr_i | input | 1 | Priority write strobe |
| prio_idx_i | input | ID_W | Line addressed by the priority write |
| prio_val_i | input | 8 | Priority byte; only upper PRIO_BITS are stored |
| ack_i | input | 1 | Core accepted an interrupt |
| ack_id_i | input | ID_W | Line number accepted |
| group_sel_i | input | 3 | Split point between group and subpriority |
| cur_active_i | input | 1 | Core is running at an interrupt level |
| cur_prio_i | input | 8 | Priority byte of the running level |
| win_valid_o | output | 1 | A winner exists |
| win_id_o | output | ID_W | Winning line number |
| win_prio_o | output | 8 | Winning priority byte |
| preempt_o | output | 1 | Winner may preempt the running level |

## Verification
A table drives pairs of live lines through the main function. The pairs are chosen to separate a plain lower-value win, an equal-value tie settled by line number, a tie created only by the dropped low bits, and the extreme line numbers 0 and 239. The same pairs are run with several grouping selectors and running levels. Those cases show the difference between a strictly smaller group, an equal group with different subpriority, a selector with no group bits, and an idle core. Directed sequences then cover edge-only request capture, set-over-clear collisions, enable gating and the exact cycle at which a rewritten priority takes effect.

// File: rtl/irq_arb_pkg.sv
// Package: shared helpers for the grouped-priority interrupt arbiter.
// Assumes priority bytes are 8 bits wide and the grouping selector is 3 bits.
package irq_arb_pkg;

    localparam int PRIO_BYTE_W = 8;
    localparam int GROUP_SEL_W = 3;

    // Mask that keeps only the preemption-group bits [7:g+1] of a priority byte.
    function automatic logic [PRIO_BYTE_W-1:0] group_mask(input logic [GROUP_SEL_W-1:0] g);
        logic [3:0] sh;
        sh = {1'b0, g} + 4'd1;
        return 8'hFF << sh;
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
// Module: per-line state bank. Holds the pending, enable and priority
// registers of every request line and flags the lines that may compete.
// Assumes index inputs at or above NUM_IRQ address nothing.
module irq_src_bank #(
    parameter int NUM_IRQ   = 240,
    parameter int PRIO_BITS = 4,
    localparam int ID_W     = $clog2(NUM_IRQ)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_IRQ-1:0]                  irq_i,
    input  logic                                en_wr_i,
    input  logic [ID_W-1:0]                     en_idx_i,
    input  logic                                en_val_i,
    input  logic                                pend_wr_i,
    input  logic [ID_W-1:0]                     pend_idx_i,
    input  logic                                pend_val_i,
    input  logic                                prio_wr_i,
    input  logic [ID_W-1:0]                     prio_idx_i,
    input  logic [7:0]                          prio_val_i,
    input  logic                                ack_i,
    input  logic [ID_W-1:0]                     ack_id_i,
    output logic [NUM_IRQ-1:0]                  live_o,
    output logic [NUM_IRQ-1:0][PRIO_BITS-1:0]   prio_o
);

    // Low priority bits are dropped on purpose; named so they count as unused.
    logic [7:0] prio_val_unused;
    assign prio_val_unused = prio_val_i;

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
        logic                 prev_q;
        logic                 pend_q;
        logic                 en_q;
        logic [PRIO_BITS-1:0] prio_q;
        logic                 rise;
        logic                 sw_set;
        logic                 sw_clr;
        logic                 ack_hit;

        // Decode the per-line events of this cycle.
        always_comb begin
            rise    = irq_i[k] & ~prev_q;
            sw_set  = pend_wr_i & (pend_idx_i == ID_W'(k)) & pend_val_i;
            sw_clr  = pend_wr_i & (pend_idx_i == ID_W'(k)) & ~pend_val_i;
            ack_hit = ack_i & (ack_id_i == ID_W'(k));
        end

        // Update line state; a set beats a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
                en_q   <= 1'b0;
                prio_q <= '0;
            end else begin
                prev_q <= irq_i[k];
                pend_q <= (rise | sw_set) | (pend_q & ~(sw_clr | ack_hit));
                if (en_wr_i && en_idx_i == ID_W'(k))
                    en_q <= en_val_i;
                if (prio_wr_i && prio_idx_i == ID_W'(k))
                    prio_q <= prio_val_i[7 -: PRIO_BITS];
            end
        end

        assign live_o[k] = pend_q & en_q;
        assign prio_o[k] = prio_q;

        AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_i[k]) |=> pend_q);                                   // R2

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_hit && !rise && !sw_set) |=> !pend_q);                    // R4
    end

endmodule

// File: rtl/irq_prio_tree.sv
// Module: combinational tournament tree. Each node forwards the more
// urgent of its two children; the left child holds lower line numbers,
// so it also wins ties. Assumes NUM_IRQ >= 2.
module irq_prio_tree #(
    parameter int NUM_IRQ   = 240,
    parameter int PRIO_BITS = 4,
    localparam int ID_W     = $clog2(NUM_IRQ),
    localparam int LVLS     = $clog2(NUM_IRQ),
    localparam int LEAVES   = 1 << LVLS
) (
    input  logic [NUM_IRQ-1:0]                  live_i,
    input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0]   prio_i,
    output logic                                any_o,
    output logic [ID_W-1:0]                     id_o,
    output logic [PRIO_BITS-1:0]                prio_o
);

    for (genvar l = 0; l <= LVLS; l++) begin : lv
        localparam int W = LEAVES >> l;
        logic [W-1:0]                 v;
        logic [W-1:0][ID_W-1:0]       id;
        logic [W-1:0][PRIO_BITS-1:0]  p;

        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < W; i++) begin : g_in
                if (i < NUM_IRQ) begin : g_real
                    assign v[i]  = live_i[i];
                    assign id[i] = ID_W'(i);
                    assign p[i]  = prio_i[i];
                end else begin : g_pad
                    assign v[i]  = 1'b0;
                    assign id[i] = '0;
                    assign p[i]  = '0;
                end
            end
        end else begin : g_node
            for (genvar j = 0; j < W; j++) begin : g_cmp
                logic take_left;
                // Pick left unless only right is live or right is strictly more urgent.
                always_comb begin
                    take_left = lv[l-1].v[2*j] &&
                                (!lv[l-1].v[2*j+1] || (lv[l-1].p[2*j] <= lv[l-1].p[2*j+1]));
                end
                assign v[j]  = lv[l-1].v[2*j] | lv[l-1].v[2*j+1];
                assign id[j] = take_left ? lv[l-1].id[2*j] : lv[l-1].id[2*j+1];
                assign p[j]  = take_left ? lv[l-1].p[2*j]  : lv[l-1].p[2*j+1];
            end
        end
    end

    assign any_o  = lv[LVLS].v[0];
    assign id_o   = lv[LVLS].id[0];
    assign prio_o = lv[LVLS].p[0];

    // Root must report a winner exactly when some leaf is live.
    always_comb begin
        AST_ROOT_MATCHES_LEAVES: assert (any_o == (|live_i));               // R5
    end

endmodule

// File: rtl/irq_preempt_gate.sv
// Module: output stage. Expands the winning priority to a byte, applies
// the group split to decide preemption, and registers the result.
// Assumes the current-priority input is a full priority byte.
module irq_preempt_gate #(
    parameter int NUM_IRQ   = 240,
    parameter int PRIO_BITS = 4,
    localparam int ID_W     = $clog2(NUM_IRQ)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cand_valid_i,
    input  logic [ID_W-1:0]       cand_id_i,
    input  logic [PRIO_BITS-1:0]  cand_prio_i,
    input  logic [2:0]            group_sel_i,
    input  logic                  cur_active_i,
    input  logic [7:0]            cur_prio_i,
    output logic                  win_valid_o,
    output logic [ID_W-1:0]       win_id_o,
    output logic [7:0]            win_prio_o,
    output logic                  preempt_o
);
    import irq_arb_pkg::*;

    logic [7:0] cand_byte;
    logic [7:0] gmask;
    logic       wants_preempt;

    // Place stored bits at the top of the byte and compare group fields.
    always_comb begin
        cand_byte     = 8'(cand_prio_i) << (8 - PRIO_BITS);
        gmask         = group_mask(group_sel_i);
        wants_preempt = cand_valid_i &&
                        (!cur_active_i || ((cand_byte & gmask) < (cur_prio_i & gmask)));
    end

    // Register the arbitration result once per cycle; zero when nothing competes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid_o <= 1'b0;
            win_id_o    <= '0;
            win_prio_o  <= '0;
            preempt_o   <= 1'b0;
        end else begin
            win_valid_o <= cand_valid_i;
            win_id_o    <= cand_valid_i ? cand_id_i : '0;
            win_prio_o  <= cand_valid_i ? cand_byte : '0;
            preempt_o   <= wants_preempt;
        end
    end

    AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        (preempt_o && $past(cur_active_i)) |->
        ((win_prio_o & group_mask($past(group_sel_i))) <
         ($past(cur_prio_i) & group_mask($past(group_sel_i)))));              // R11

    AST_IDLE_PREEMPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid_o && !$past(cur_active_i)) |-> preempt_o);                // R10

    AST_PREEMPT_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cand_valid_i) |-> (!preempt_o && win_id_o == '0));            // R12

endmodule

// File: rtl/irq_group_arbiter.sv
// Module: top of the grouped-priority interrupt arbiter. Connects the
// line bank, the comparison tree and the registered preemption gate.
// Assumes 3 <= PRIO_BITS <= 8 and NUM_IRQ between 2 and 240.
module irq_group_arbiter #(
    parameter int NUM_IRQ   = 240,
    parameter int PRIO_BITS = 4,
    localparam int ID_W     = $clog2(NUM_IRQ)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  irq_i,
    input  logic                en_wr_i,
    input  logic [ID_W-1:0]     en_idx_i,
    input  logic                en_val_i,
    input  logic                pend_wr_i,
    input  logic [ID_W-1:0]     pend_idx_i,
    input  logic                pend_val_i,
    input  logic                prio_wr_i,
    input  logic [ID_W-1:0]     prio_idx_i,
    input  logic [7:0]          prio_val_i,
    input  logic                ack_i,
    input  logic [ID_W-1:0]     ack_id_i,
    input  logic [2:0]          group_sel_i,
    input  logic                cur_active_i,
    input  logic [7:0]          cur_prio_i,
    output logic                win_valid_o,
    output logic [ID_W-1:0]     win_id_o,
    output logic [7:0]          win_prio_o,
    output logic                preempt_o
);

    logic [NUM_IRQ-1:0]                 live;
    logic [NUM_IRQ-1:0][PRIO_BITS-1:0]  prio_tab;
    logic                               cand_valid;
    logic [ID_W-1:0]                    cand_id;
    logic [PRIO_BITS-1:0]               cand_prio;
    logic [NUM_IRQ-1:0]                 live_prev_q;

    irq_src_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_i      (irq_i),
        .en_wr_i    (en_wr_i),
        .en_idx_i   (en_idx_i),
        .en_val_i   (en_val_i),
        .pend_wr_i  (pend_wr_i),
        .pend_idx_i (pend_idx_i),
        .pend_val_i (pend_val_i),
        .prio_wr_i  (prio_wr_i),
        .prio_idx_i (prio_idx_i),
        .prio_val_i (prio_val_i),
        .ack_i      (ack_i),
        .ack_id_i   (ack_id_i),
        .live_o     (live),
        .prio_o     (prio_tab)
    );

    irq_prio_tree #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_tree (
        .live_i (live),
        .prio_i (prio_tab),
        .any_o  (cand_valid),
        .id_o   (cand_id),
        .prio_o (cand_prio)
    );

    irq_preempt_gate #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .cand_valid_i (cand_valid),
        .cand_id_i    (cand_id),
        .cand_prio_i  (cand_prio),
        .group_sel_i  (group_sel_i),
        .cur_active_i (cur_active_i),
        .cur_prio_i   (cur_prio_i),
        .win_valid_o  (win_valid_o),
        .win_id_o     (win_id_o),
        .win_prio_o   (win_prio_o),
        .preempt_o    (preempt_o)
    );

    // Keep last cycle's competing set so the output can be checked against it.
    always_ff @(posedge clk) begin
        if (!rst_n) live_prev_q <= '0;
        else        live_prev_q <= live;
    end

    AST_WIN_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> live_prev_q[win_id_o]);                              // R5

    AST_IDLE_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (live_prev_q == '0) |-> !win_valid_o);                               // R12

endmodule

// File: tb/irq_group_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_group_arbiter_tb_top;

    localparam int N    = 240;
    localparam int PB   = 4;
    localparam int ID_W = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    irq;
    logic            en_wr, en_val, pend_wr, pend_val, prio_wr, ack;
    logic [ID_W-1:0] en_idx, pend_idx, prio_idx, ack_id;
    logic [7:0]      prio_val, cur_prio;
    logic [2:0]      group_sel;
    logic            cur_active;
    logic            win_valid, preempt;
    logic [ID_W-1:0] win_id;
    logic [7:0]      win_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_group_arbiter #(.NUM_IRQ(N), .PRIO_BITS(PB)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .en_wr_i(en_wr), .en_idx_i(en_idx), .en_val_i(en_val),
        .pend_wr_i(pend_wr), .pend_idx_i(pend_idx), .pend_val_i(pend_val),
        .prio_wr_i(prio_wr), .prio_idx_i(prio_idx), .prio_val_i(prio_val),
        .ack_i(ack), .ack_id_i(ack_id),
        .group_sel_i(group_sel), .cur_active_i(cur_active), .cur_prio_i(cur_prio),
        .win_valid_o(win_valid), .win_id_o(win_id), .win_prio_o(win_prio),
        .preempt_o(preempt)
    );

    typedef struct packed {
        logic [7:0] a_id; logic [7:0] a_p;
        logic [7:0] b_id; logic [7:0] b_p;
        logic [2:0] g;    logic act;  logic [7:0] cur;
        logic ev; logic [7:0] eid; logic [7:0] ep; logic epre;
    } vec_t;

    // Two live lines per row; expected winner and preempt decided by R6, R9, R10, R11.
    localparam vec_t VECS [10] = '{
        '{8'd5,   8'h40, 8'd9,  8'h20, 3'd3, 1'b0, 8'h00, 1'b1, 8'd9,   8'h20, 1'b1},
        '{8'd5,   8'h30, 8'd9,  8'h30, 3'd3, 1'b0, 8'h00, 1'b1, 8'd5,   8'h30, 1'b1},
        '{8'd200, 8'h10, 8'd17, 8'h1F, 3'd3, 1'b1, 8'h20, 1'b1, 8'd17,  8'h10, 1'b1},
        '{8'd3,   8'h50, 8'd4,  8'h60, 3'd6, 1'b1, 8'h70, 1'b1, 8'd3,   8'h50, 1'b0},
        '{8'd3,   8'h50, 8'd4,  8'h60, 3'd5, 1'b1, 8'h80, 1'b1, 8'd3,   8'h50, 1'b1},
        '{8'd1,   8'h00, 8'd2,  8'h10, 3'd7, 1'b1, 8'hF0, 1'b1, 8'd1,   8'h00, 1'b0},
        '{8'd7,   8'h40, 8'd8,  8'h70, 3'd3, 1'b1, 8'h4F, 1'b1, 8'd7,   8'h40, 1'b0},
        '{8'd10,  8'h30, 8'd11, 8'h50, 3'd4, 1'b1, 8'h40, 1'b1, 8'd10,  8'h30, 1'b1},
        '{8'd239, 8'h00, 8'd0,  8'h10, 3'd0, 1'b0, 8'h00, 1'b1, 8'd239, 8'h00, 1'b1},
        '{8'd50,  8'h50, 8'd51, 8'h40, 3'd4, 1'b1, 8'h50, 1'b1, 8'd51,  8'h40, 1'b0}
    };

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic settle();
        tick(); tick();
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        irq = '0; en_wr = 0; en_val = 0; pend_wr = 0; pend_val = 0;
        prio_wr = 0; ack = 0; en_idx = '0; pend_idx = '0; prio_idx = '0;
        ack_id = '0; prio_val = '0; group_sel = 3'd0; cur_active = 0; cur_prio = '0;
        rst_n = 0; tick(); tick(); rst_n = 1;
    endtask

    task automatic wr_en(input int id, input bit v);
        en_wr = 1; en_idx = ID_W'(id); en_val = v; tick(); en_wr = 0;
    endtask

    task automatic wr_pend(input int id, input bit v);
        pend_wr = 1; pend_idx = ID_W'(id); pend_val = v; tick(); pend_wr = 0;
    endtask

    task automatic wr_prio(input int id, input logic [7:0] v);
        prio_wr = 1; prio_idx = ID_W'(id); prio_val = v; tick(); prio_wr = 0;
    endtask

    task automatic do_ack(input int id);
        ack = 1; ack_id = ID_W'(id); tick(); ack = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Table walk: R6 R7 R9 R10 R11
        for (int n = 0; n < 10; n++) begin
            do_reset();
            group_sel = VECS[n].g; cur_active = VECS[n].act; cur_prio = VECS[n].cur;
            wr_prio(VECS[n].a_id, VECS[n].a_p);
            wr_prio(VECS[n].b_id, VECS[n].b_p);
            wr_en(VECS[n].a_id, 1'b1);
            wr_en(VECS[n].b_id, 1'b1);
            wr_pend(VECS[n].a_id, 1'b1);
            wr_pend(VECS[n].b_id, 1'b1);
            settle();
            chk(win_valid == VECS[n].ev, "R6 valid", win_valid, VECS[n].ev);
            chk(win_id == VECS[n].eid, "R6 winner id", win_id, VECS[n].eid);
            chk(win_prio == VECS[n].ep, "R7 winner prio", win_prio, VECS[n].ep);
            chk(preempt == VECS[n].epre, "R9 R10 R11 preempt", preempt, VECS[n].epre);
        end

        // R1 R12: reset state
        do_reset();
        chk(win_valid == 0 && preempt == 0, "R1 valid/preempt after reset", {win_valid, preempt}, 0);
        chk(win_id == 0 && win_prio == 0, "R12 id/prio idle", {win_id, win_prio}, 0);
        wr_en(3, 1'b1); wr_pend(3, 1'b1); settle();
        chk(win_id == 3 && win_prio == 8'h00, "R1 priority reset to zero", win_prio, 0);

        // R2: edge capture only
        do_reset();
        wr_en(12, 1'b1);
        irq[12] = 1'b1; settle(); tick();
        chk(win_valid && win_id == 12, "R2 rising edge sets pending", win_id, 12);
        do_ack(12); settle();
        chk(!win_valid, "R4 ack clears, R2 held level no re-set", win_valid, 0);
        irq[12] = 1'b0; tick(); irq[12] = 1'b1; settle();
        chk(win_valid && win_id == 12, "R2 new edge sets again", win_id, 12);

        // R3: software set/clear and collision
        do_reset();
        wr_en(20, 1'b1); wr_pend(20, 1'b1); settle();
        chk(win_valid && win_id == 20, "R3 software set", win_id, 20);
        wr_pend(20, 1'b0); settle();
        chk(!win_valid, "R3 software clear", win_valid, 0);
        pend_wr = 1; pend_idx = 8'd20; pend_val = 1; ack = 1; ack_id = 8'd20;
        tick(); pend_wr = 0; ack = 0; settle();
        chk(win_valid && win_id == 20, "R3 set beats ack clear", win_valid, 1);
        irq[20] = 1'b1; pend_wr = 1; pend_idx = 8'd20; pend_val = 0;
        tick(); pend_wr = 0; settle();
        chk(win_valid && win_id == 20, "R3 edge beats software clear", win_valid, 1);

        // R5: enable gating
        do_reset();
        wr_pend(40, 1'b1); settle();
        chk(!win_valid, "R5 disabled line does not compete", win_valid, 0);
        wr_en(40, 1'b1); settle();
        chk(win_valid && win_id == 40, "R5 pending kept, wins once enabled", win_id, 40);
        wr_prio(40, 8'h5A); settle();
        chk(win_prio == 8'h50, "R7 low bits dropped", win_prio, 8'h50);
        wr_en(40, 1'b0); settle();
        chk(!win_valid && !preempt, "R12 nothing live", win_valid, 0);

        // R8: priority rewrite timing
        do_reset();
        wr_prio(30, 8'h20); wr_prio(31, 8'h30);
        wr_en(30, 1'b1); wr_en(31, 1'b1);
        wr_pend(30, 1'b1); wr_pend(31, 1'b1); settle();
        chk(win_id == 30, "R8 initial winner", win_id, 30);
        wr_prio(31, 8'h10);
        chk(win_id == 30, "R8 old result right after write edge", win_id, 30);
        tick();
        chk(win_id == 31 && win_prio == 8'h10, "R8 new result one edge later", win_id, 31);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule